// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between a UART core and the chip pins and applies serial-infrared pulse coding in both directions. On the way out it turns each zero bit of the UART's NRZ transmit stream into one short pulse, and it sends nothing for a one bit. On the way in it detects pulses on the receive pin and stretches each one into a low level one bit time long, so the UART sees ordinary NRZ data. Each direction has its own enable. A disabled direction is a straight wire, and its coding logic is held cleared.

A five-bit configuration register holds the two enables, a transmit and a receive polarity, and the transmit width mode. The width mode picks between two pulse lengths. In baud-relative mode the pulse lasts three ticks of the 16x baud enable. In fixed mode the pulse lasts `FIX_TICKS` ticks of a separate system timer tick, whatever the baud rate. Both streams are free-running bit lines timed by the 16x enable. They carry no valid/ready handshake and accept no back-pressure: the UART side and the pin side are sampled every cycle.

Top module: `sir_codec`

## Requirements
- R1: The configuration register resets to 0. It is loaded from `cfg_wdata_i` on a cycle where `cfg_we_i` is high. Its layout is: bit 0 transmit enable, bit 1 receive enable, bit 2 fixed-width mode, bit 3 transmit polarity, bit 4 receive polarity. Bits 31:5 of `cfg_rdata_o` always read 0.
- R2: While the transmit enable is 0, `ir_txd_o` equals `uart_txd_i` in every cycle and the encoder state stays cleared.
- R3: While the receive enable is 0, `uart_rxd_o` equals `rxd_pin_i` in every cycle and the decoder state stays cleared.
- R4: With transmit enabled and fixed mode 0, the encoder samples `uart_txd_i` at phase 0 of each bit. It restarts phase 0 when the line changes, or after 16 ticks. A zero bit gives one pulse of exactly 3 ticks, covering phases 7 to 9. A one bit gives no pulse.
- R5: With fixed mode 1, each zero bit starts at phase 7 one pulse lasting exactly `FIX_TICKS` system ticks. A pulse is started only by a new zero bit.
- R6: Transmit polarity 0 gives a high pulse on a low line. Transmit polarity 1 gives a low pulse on a high line.
- R7: Receive polarity 0 treats high pulses as zeros. Receive polarity 1 treats low pulses as zeros.
- R8: The receive pin passes through a two-flop synchronizer. Every leading edge of a pulse drives `uart_rxd_o` low for 16 ticks of the 16x enable, and a new pulse reloads the count. Pulses shorter than a tick are caught.
- R9: The fixed-width mode bit has no effect on the decoder.
- R10: With transmit enabled and no pulse active, `ir_txd_o` holds the transmit polarity bit as a steady idle level, with no extra transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Configuration write value |
| cfg_rdata_o | output | 32 | Configuration readback, upper bits zero |
| tick16_i | input | 1 | 16x baud clock enable, one cycle wide |
| sys_tick_i | input | 1 | Timer tick for the fixed pulse width |
| uart_txd_i | input | 1 | NRZ transmit data from the UART |
| ir_txd_o | output | 1 | Transmit pin |
| rxd_pin_i | input | 1 | Receive pin |
| uart_rxd_o | output | 1 | NRZ receive data to the UART |

## Verification
On the receive side, two decoder functions meet in the same cycle: the load from a new pulse and the expiry of the stretch count. When back-to-back zero bits arrive, the next pulse's edge lands within a tick of the previous stretch ending. The bench sends runs of consecutive zeros and samples mid-bit, so it can judge that the line stays low across the bit boundary. On the transmit side, a new bit start and the phase-15 wrap can fall on the same tick. Runs of zeros followed by a one provoke this, and the pulse count in every bit window must still be exact.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int CFG_W       = 5;
  localparam int REG_W       = 32;
  localparam int PULSE_START = 7;
  localparam int PULSE_LEN   = 3;

  typedef struct packed {
    logic rx_pol;
    logic tx_pol;
    logic fix_mode;
    logic rx_en;
    logic tx_en;
  } sir_cfg_t;
endpackage

// File: rtl/sir_cfg_reg.sv
module sir_cfg_reg
  import sir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [CFG_W-1:0]     wdata_i,
  output sir_cfg_t             cfg_o,
  output logic [REG_W-1:0]     rdata_o
);
  sir_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (we_i) cfg_q <= sir_cfg_t'(wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(REG_W-CFG_W){1'b0}}, cfg_q};

  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rdata_o == {{(REG_W-CFG_W){1'b0}}, $past(wdata_i)});
endmodule

// File: rtl/sir_tx_encoder.sv
module sir_tx_encoder
  import sir_pkg::*;
#(
  parameter int PHASES    = 16,
  parameter int FIX_TICKS = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fix_mode_i,
  input  logic tick16_i,
  input  logic sys_tick_i,
  input  logic txd_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PHASES);
  localparam int FW = $clog2(FIX_TICKS + 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          bit_q, bit_d;
  logic          rel_q;
  logic [FW-1:0] fix_q;
  logic          in_win, fix_start;

  always_comb begin
    phase_d = phase_q + PW'(1);
    bit_d   = bit_q;
    if (txd_i != bit_q || phase_q == PW'(PHASES - 1)) begin
      phase_d = '0;
      bit_d   = txd_i;
    end
    in_win    = !bit_d && int'(phase_d) >= PULSE_START &&
                int'(phase_d) < PULSE_START + PULSE_LEN;
    fix_start = !bit_d && int'(phase_d) == PULSE_START;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bit_q   <= 1'b1;
      rel_q   <= 1'b0;
      fix_q   <= '0;
    end else if (!en_i) begin
      phase_q <= '0;
      bit_q   <= 1'b1;
      rel_q   <= 1'b0;
      fix_q   <= '0;
    end else begin
      if (tick16_i) begin
        phase_q <= phase_d;
        bit_q   <= bit_d;
        rel_q   <= in_win;
      end
      if (tick16_i && fix_start)         fix_q <= FW'(FIX_TICKS);
      else if (sys_tick_i && fix_q != 0) fix_q <= fix_q - FW'(1);
    end
  end

  assign pulse_o = fix_mode_i ? (fix_q != '0) : rel_q;

  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (fix_q == '0 && !rel_q && bit_q));
  p_no_pulse_for_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> !bit_q);
  p_pulse_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> (int'(phase_q) >= PULSE_START && int'(phase_q) < PULSE_START + PULSE_LEN));
  p_fix_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fix_q) <= FIX_TICKS);
endmodule

// File: rtl/sir_rx_decoder.sv
module sir_rx_decoder #(
  parameter int PHASES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pol_i,
  input  logic tick16_i,
  input  logic pin_i,
  output logic nrz_o
);
  localparam int CW = $clog2(PHASES + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_i ^ pol_i};
      if (rise)                        cnt_q <= CW'(PHASES);
      else if (tick16_i && cnt_q != 0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign nrz_o = (cnt_q == '0);

  p_edge_drives_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rise) |=> !nrz_o);
  p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !rise && !tick16_i) |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> nrz_o);
endmodule

// File: rtl/sir_codec.sv
module sir_codec
  import sir_pkg::*;
#(
  parameter int PHASES    = 16,
  parameter int FIX_TICKS = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             tick16_i,
  input  logic             sys_tick_i,
  input  logic             uart_txd_i,
  output logic             ir_txd_o,
  input  logic             rxd_pin_i,
  output logic             uart_rxd_o
);
  sir_cfg_t cfg;
  logic     tx_pulse, rx_nrz;

  sir_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .rdata_o(cfg_rdata_o)
  );

  sir_tx_encoder #(.PHASES(PHASES), .FIX_TICKS(FIX_TICKS)) u_enc (
    .clk(clk), .rst_n(rst_n), .en_i(cfg.tx_en), .fix_mode_i(cfg.fix_mode),
    .tick16_i(tick16_i), .sys_tick_i(sys_tick_i), .txd_i(uart_txd_i),
    .pulse_o(tx_pulse)
  );

  sir_rx_decoder #(.PHASES(PHASES)) u_dec (
    .clk(clk), .rst_n(rst_n), .en_i(cfg.rx_en), .pol_i(cfg.rx_pol),
    .tick16_i(tick16_i), .pin_i(rxd_pin_i), .nrz_o(rx_nrz)
  );

  assign ir_txd_o   = cfg.tx_en ? (tx_pulse ^ cfg.tx_pol) : uart_txd_i;
  assign uart_rxd_o = cfg.rx_en ? rx_nrz : rxd_pin_i;
endmodule

// File: tb/sim_sir_codec.sv
module sim_sir_codec;
  localparam int FIX = 10;
  localparam int BITCLK = 64;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic tick16 = 0, sys_tick = 1;
  logic uart_txd = 1, ir_txd, rxd_pin = 0, uart_rxd;
  int total = 0, bad = 0;
  int tctr = 0;

  sir_codec #(.PHASES(16), .FIX_TICKS(FIX)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .tick16_i(tick16), .sys_tick_i(sys_tick),
    .uart_txd_i(uart_txd), .ir_txd_o(ir_txd), .rxd_pin_i(rxd_pin),
    .uart_rxd_o(uart_rxd)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tctr   <= (tctr == 3) ? 0 : tctr + 1;
    tick16 <= (tctr == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [4:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic align_tick;
    do @(negedge clk); while (tick16 !== 1'b1);
  endtask

  task automatic t_reset;
    #1;
    chk(cfg_rdata == 32'd0, "R1 reset value", cfg_rdata, 0);
    chk(ir_txd == uart_txd, "R2 reset tx bypass", ir_txd, uart_txd);
    chk(uart_rxd == rxd_pin, "R3 reset rx bypass", uart_rxd, rxd_pin);
  endtask

  task automatic t_cfg;
    wr_cfg(5'h1F); #1;
    chk(cfg_rdata == 32'h1F, "R1 all bits, upper zero", cfg_rdata, 32'h1F);
    wr_cfg(5'h0A); #1;
    chk(cfg_rdata == 32'h0A, "R1 pattern", cfg_rdata, 32'h0A);
    wr_cfg(5'h00); #1;
    chk(cfg_rdata == 32'h0, "R1 clear", cfg_rdata, 0);
  endtask

  task automatic t_tx_bypass;
    logic [15:0] pat = 16'b1011_0010_1110_0101;
    for (int i = 0; i < 16; i++) begin
      int mism = 0;
      @(negedge clk); uart_txd = pat[i];
      for (int k = 0; k < 5; k++) begin
        #1; if (ir_txd !== uart_txd) mism++;
        @(negedge clk);
      end
      chk(mism == 0, "R2 tx bypass bit", mism, 0);
    end
    uart_txd = 1;
  endtask

  task automatic t_tx_enc(input bit pol, input bit fixm);
    logic [10:0] pat = 11'b011_1010_0110;
    int steady_bad = 0;
    wr_cfg({1'b0, pol, fixm, 1'b0, 1'b1});
    uart_txd = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      if (ir_txd !== pol) steady_bad++;
    end
    chk(steady_bad == 0, "R10 idle level steady", steady_bad, 0);
    align_tick();
    for (int b = 0; b < 11; b++) begin
      int act = 0, first = -1, exp;
      uart_txd = pat[b];
      for (int k = 0; k < BITCLK; k++) begin
        @(negedge clk); #1;
        if ((ir_txd ^ pol) == 1'b1) begin
          act++;
          if (first < 0) first = k;
        end
      end
      exp = pat[b] ? 0 : (fixm ? FIX : 12);
      if (fixm) chk(act == exp, pol ? "R5 R6 fixed width count" : "R5 fixed width count", act, exp);
      else      chk(act == exp, pol ? "R4 R6 3/16 width count" : "R4 3/16 width count", act, exp);
      if (!pat[b])
        chk(first >= 24 && first <= 34, "R4 R5 pulse starts at phase 7", first, 29);
    end
    uart_txd = 1;
    wr_cfg(5'h00);
  endtask

  task automatic t_rx_bypass;
    logic [15:0] pat = 16'b0110_1001_1100_1010;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); rxd_pin = pat[i]; #1;
      chk(uart_rxd == rxd_pin, "R3 rx bypass bit", uart_rxd, rxd_pin);
    end
  endtask

  task automatic t_rx_dec(input bit pol, input bit fixm, input int plen);
    logic [10:0] pat = 11'b100_0110_1001;
    rxd_pin = pol;
    wr_cfg({pol, 1'b0, fixm, 1'b1, 1'b0});
    repeat (4) @(negedge clk); #1;
    chk(uart_rxd == 1'b1, "R8 idle high", uart_rxd, 1);
    align_tick();
    for (int b = 0; b < 11; b++) begin
      for (int k = 0; k < BITCLK; k++) begin
        rxd_pin = (!pat[b] && k >= 28 && k < 28 + plen) ? ~pol : pol;
        @(negedge clk);
        if (k == 50) begin
          #1;
          chk(uart_rxd == pat[b], fixm ? "R9 R7 R8 decode with mode set" : "R7 R8 decode bit",
              uart_rxd, pat[b]);
        end
      end
    end
    rxd_pin = pol;
    repeat (80) @(negedge clk);
    wr_cfg(5'h00);
    rxd_pin = 0;
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cfg();
    t_tx_bypass();
    t_tx_enc(0, 0);
    t_tx_enc(1, 0);
    t_tx_enc(0, 1);
    t_tx_enc(1, 1);
    t_rx_bypass();
    t_rx_dec(0, 0, 12);
    t_rx_dec(1, 0, 12);
    t_rx_dec(0, 1, 2);
    t_rx_dec(1, 1, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule